// File: doc/BRIEF.md
# Toggle-Handshake Bundled-Data Pipeline

This block is a chain of pipeline stages that moves data words from a sender to a receiver using a two-phase handshake. Each direction has its own single wire. The sender marks a new word by changing the level of its request wire. The receiver marks that it has taken a word by changing the level of its acknowledge wire. The value of the new level carries no meaning: a rise and a fall each count as one event. The data travels beside the request wire as a plain parallel bus. The request edge alone says when the bus may be read.

Inside a clocked device, the block samples the incoming request and acknowledge wires through a short synchroniser. It accepts a change only after the new level has been seen on two samples in a row. Each stage holds one word. It is full while the phase of its outgoing request differs from the phase of the acknowledge that returns to it. A stage takes a new word only when it is empty and its incoming request phase differs from its own acknowledge phase. When it takes the word, it flips both its acknowledge and its outgoing request.

Top module: `tpb_pipe`

## Requirements
- R1: During and right after a synchronous reset, `up_ack`, `down_req` and `down_data` are all 0, and every stage is empty.
- R2: Each accepted toggle of `up_req`, rising or falling, produces exactly one toggle of `up_ack`, which leaves `up_ack` equal to `up_req`.
- R3: Words leave on `down_data` in the order they were accepted, with unchanged values. Each word comes with exactly one toggle of `down_req`. `down_req` does not toggle again until `down_ack` has toggled back to match it.
- R4: While a word is offered downstream (`down_req` differs from `down_ack`), `down_data` and `down_req` hold steady.
- R5: With no downstream acknowledge, the chain accepts exactly STAGES words. A further request gets no `up_ack` toggle until space frees up, and it is then accepted.
- R6: A level change on `up_req` or `down_ack` is taken only once the synchronised level has been the same on two successive samples. A pulse lasting one sampling cycle has no effect on `up_ack`, `down_req` or `down_data`.
- R7: `up_data` is read only in the cycle the first stage captures. Changing it after `up_ack` has toggled does not alter the word that is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| up_data | input | DATA_W | Bundled word from the sender |
| up_req | input | 1 | Sender request; a toggle marks a new word |
| up_ack | output | 1 | Acknowledge to the sender; toggles once a word is taken |
| down_data | output | DATA_W | Bundled word offered to the receiver |
| down_req | output | 1 | Request to the receiver; toggles when a word is offered |
| down_ack | input | 1 | Receiver acknowledge; a toggle frees the last stage |

## Verification
The assertions rely on the sender obeying the handshake. It holds `up_data` steady from its request toggle until `up_ack` matches again, and it never toggles `up_req` while a request is still open. The receiver likewise toggles `down_ack` only in answer to an open `down_req`. The bench keeps to these rules by waiting for phase agreement before each new toggle. The only exception is the single-cycle pulses used to probe the filter: they return to the old level and so leave the phase unchanged. Random gaps on both sides, drawn from a fixed seed, vary the spacing between handshakes. Directed runs fill the chain to capacity and pulse each input wire.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  // number of flops that resynchronise an incoming toggle wire
  localparam int unsigned SYNC_DEPTH = 2;
  // a handshake phase is one bit; a mismatch between two phases is an open event
  typedef logic phase_t;

  function automatic logic open_event(input phase_t req_ph, input phase_t ack_ph);
    return req_ph != ack_ph;
  endfunction
endpackage

// File: rtl/tpb_toggle_filter.sv
module tpb_toggle_filter
  import tpb_pkg::*;
#(
  parameter int unsigned DEPTH = SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output phase_t level_out
);
  localparam int unsigned MSB = DEPTH - 1;

  logic [MSB:0] sync_q;
  logic         hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      hist_q    <= 1'b0;
      level_out <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], raw_in};
      hist_q <= sync_q[MSB];
      // accept the new level only when two successive samples agree
      if (sync_q[MSB] == hist_q) level_out <= hist_q;
    end
  end

  // R6: any change of the filtered level is backed by two equal samples
  assert_filter_two_samples_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_out) |-> (level_out == $past(sync_q[MSB], 1)) && (level_out == $past(sync_q[MSB], 2)));
endmodule

// File: rtl/tpb_stage.sv
module tpb_stage
  import tpb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            in_req,
  input  logic [DATA_W-1:0] in_data,
  output phase_t            ack_out,
  output phase_t            req_out,
  output logic [DATA_W-1:0] out_data,
  input  phase_t            ack_in
);
  logic full;
  logic take;

  assign full = open_event(req_out, ack_in);
  assign take = !full && open_event(in_req, ack_out);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_out  <= 1'b0;
      req_out  <= 1'b0;
      out_data <= '0;
    end else if (take) begin
      out_data <= in_data;
      ack_out  <= ~ack_out;
      req_out  <= ~req_out;
    end
  end

  // R4: a held word is not overwritten while it is still offered
  assert_hold_word_R4: assert property (@(posedge clk) disable iff (rst)
    (req_out != ack_in) |=> $stable(out_data));

  // R2: acknowledge only moves in answer to an open incoming request
  assert_ack_answers_req_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ack_out) |-> $past(in_req != ack_out));

  // R3: a new offer downstream is made only after the previous one was answered
  assert_one_offer_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(req_out) |-> $past(req_out == ack_in));
endmodule

// File: rtl/tpb_pipe.sv
module tpb_pipe
  import tpb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_req,
  output logic              up_ack,
  output logic [DATA_W-1:0] down_data,
  output logic              down_req,
  input  logic              down_ack
);
  localparam int unsigned OCC_W = $clog2(STAGES + 2);

  phase_t            up_req_f;
  phase_t            down_ack_f;
  phase_t            req_chain [STAGES+1];
  phase_t            ack_chain [STAGES+1];
  logic [DATA_W-1:0] data_chain [STAGES+1];

  tpb_toggle_filter #(.DEPTH(SYNC_DEPTH)) u_req_filt (
    .clk(clk), .rst(rst), .raw_in(up_req), .level_out(up_req_f)
  );

  tpb_toggle_filter #(.DEPTH(SYNC_DEPTH)) u_ack_filt (
    .clk(clk), .rst(rst), .raw_in(down_ack), .level_out(down_ack_f)
  );

  assign req_chain[0]       = up_req_f;
  assign data_chain[0]      = up_data;
  assign ack_chain[STAGES]  = down_ack_f;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    tpb_stage #(.DATA_W(DATA_W)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .in_req  (req_chain[g]),
      .in_data (data_chain[g]),
      .ack_out (ack_chain[g]),
      .req_out (req_chain[g+1]),
      .out_data(data_chain[g+1]),
      .ack_in  (ack_chain[g+1])
    );
  end

  assign up_ack    = ack_chain[0];
  assign down_req  = req_chain[STAGES];
  assign down_data = data_chain[STAGES];

  // occupancy tracked from boundary events, used only by the assertion below
  logic [OCC_W-1:0] occ_q;
  logic             up_ack_d, dack_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q    <= '0;
      up_ack_d <= 1'b0;
      dack_d   <= 1'b0;
    end else begin
      up_ack_d <= up_ack;
      dack_d   <= down_ack_f;
      occ_q    <= occ_q + OCC_W'(up_ack != up_ack_d) - OCC_W'(down_ack_f != dack_d);
    end
  end

  // R5: never more words inside than there are stages
  assert_occupancy_R5: assert property (@(posedge clk) disable iff (rst)
    occ_q <= OCC_W'(STAGES));

  // R1: outputs idle while reset is held
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!up_ack && !down_req && down_data == '0));
endmodule

// File: tb/tpb_pipe_bench.sv
`timescale 1ns/1ps
module tpb_pipe_bench;
  localparam int DW = 8;
  localparam int ST = 3;
  localparam int NRAND = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] up_data;
  logic          up_req;
  logic          up_ack;
  logic [DW-1:0] down_data;
  logic          down_req;
  logic          down_ack;

  always #2.5 clk = ~clk;

  tpb_pipe #(.DATA_W(DW), .STAGES(ST)) u_tpb_pipe (
    .clk(clk), .rst(rst), .up_data(up_data), .up_req(up_req), .up_ack(up_ack),
    .down_data(down_data), .down_req(down_req), .down_ack(down_ack)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q [0:63];
  int wr_idx = 0;
  int rd_idx = 0;
  bit rx_en = 0;
  int dreq_toggles = 0;
  logic dreq_prev = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pick_word();
    return DW'($urandom_range(0, (1 << DW) - 1));
  endfunction

  // counts every toggle of down_req, for R3
  always @(negedge clk) begin
    if (!rst && down_req != dreq_prev) dreq_toggles++;
    dreq_prev <= down_req;
  end

  // receiver: checks order, value and hold, then acknowledges
  initial begin
    down_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_en && !rst && down_req != down_ack) begin
        automatic logic [DW-1:0] got = down_data;
        automatic logic ph = down_req;
        automatic int gap = $urandom_range(0, 6);
        automatic bit held = 1;
        check(got == exp_q[rd_idx % 64], "R3 order/value", got, exp_q[rd_idx % 64]);
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          if (down_data != got || down_req != ph) held = 0;
        end
        check(held, "R4 offered word held", held, 1);
        rd_idx++;
        down_ack = ~down_ack;
        repeat (5) @(negedge clk);
      end
    end
  end

  task automatic push(input logic [DW-1:0] w);
    exp_q[wr_idx % 64] = w;
    wr_idx++;
    up_data = w;
    @(negedge clk);
    up_req = ~up_req;
  endtask

  task automatic wait_ack(input string tag);
    int n = 0;
    while (up_ack != up_req && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(up_ack == up_req, tag, up_ack, up_req);
    up_data = pick_word(); // R7: scramble bus after acknowledge
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; up_req = 1'b0; up_data = '0;
    repeat (4) @(negedge clk);
    check(up_ack == 0 && down_req == 0 && down_data == 0, "R1 reset outputs", {up_ack, down_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(up_ack == 0 && down_req == 0 && down_data == 0, "R1 after reset", down_data, 0);

    // capacity: receiver idle
    for (int i = 0; i < ST; i++) begin
      push(pick_word());
      wait_ack("R2 ack per toggle (fill)");
    end
    push(pick_word());
    repeat (30) @(negedge clk);
    check(up_ack != up_req, "R5 extra word not acked when full", up_ack, !up_req);
    check(dreq_toggles == 1, "R3 single offer outstanding", dreq_toggles, 1);
    check(down_data == exp_q[0], "R7 first word intact", down_data, exp_q[0]);

    // one-cycle pulse on down_ack must not free the last stage
    down_ack = ~down_ack;
    @(negedge clk);
    down_ack = ~down_ack;
    repeat (20) @(negedge clk);
    check(dreq_toggles == 1, "R6 down_ack pulse ignored", dreq_toggles, 1);
    check(up_ack != up_req, "R6 no space after pulse", up_ack, !up_req);

    rx_en = 1;
    wait_ack("R5 extra word accepted after drain");
    begin
      int n = 0;
      while (rd_idx != wr_idx && n < 2000) begin @(negedge clk); n++; end
    end
    check(rd_idx == ST + 1, "R5 all words delivered", rd_idx, ST + 1);

    // one-cycle pulse on up_req with an empty chain
    begin
      automatic int t0 = dreq_toggles;
      up_req = ~up_req;
      @(negedge clk);
      up_req = ~up_req;
      repeat (20) @(negedge clk);
      check(up_ack == up_req, "R6 up_req pulse not acked", up_ack, up_req);
      check(dreq_toggles == t0, "R6 up_req pulse not forwarded", dreq_toggles, t0);
    end

    // random traffic
    for (int i = 0; i < NRAND; i++) begin
      repeat ($urandom_range(0, 5)) @(negedge clk);
      push(pick_word());
      wait_ack("R2 ack per toggle (random)");
    end
    begin
      int n = 0;
      while (rd_idx != wr_idx && n < 5000) begin @(negedge clk); n++; end
    end
    repeat (10) @(negedge clk);
    check(rd_idx == wr_idx, "R3 all random words delivered", rd_idx, wr_idx);
    check(dreq_toggles == wr_idx, "R3 one down_req toggle per word", dreq_toggles, wr_idx);
    check(up_ack == up_req, "R2 final phase agreement", up_ack, up_req);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule